// File: doc/BRIEF.md
# Fixed-Point Two-Layer Perceptron Core

This block evaluates a tiny feedforward network. It has two unsigned 3-bit inputs, a hidden layer of two neurons and a single output neuron. Each neuron forms a bias plus a weighted sum of its inputs, then passes that net value through an activation function. A 3-bit code chooses the activation at run time from five piecewise-linear shapes. All weights and biases are constants fixed at elaboration.

One input pair travels through the core per handshake. The pair and the activation code are taken when `in_valid` and `in_ready` are both high. The hidden layer is computed in the acceptance cycle and stored in a register. The output neuron is evaluated from that register in the next cycle. The result is then held on `y` with `out_valid` high until the consumer raises `out_ready`. Only one pair is in flight at any time.

Top module: `mlp_core`

## Requirements
- R1: Weights and biases are 7-bit two's complement values with 4 fractional bits, so 16 raw units stand for 1.0. Inputs are unsigned integers from 0 to 7. `y` is a signed value with 4 fractional bits, and the internal sums never overflow.
- R2: The hidden neurons use a bias of +1.0 and a unit-input weight of -1.5 (neuron 0) or -0.5 (neuron 1). Both use a weight of +1.0 on `in_a` and +1.0 on `in_b`. In raw units, net0 = -8 + 16(a+b) and net1 = 8 + 16(a+b).
- R3: The output neuron computes net = floor((256 - 128 - 32*h0 + 16*h1) / 16) from the raw hidden outputs h0 and h1. This is a bias of +1.0, a unit weight of -0.5, a weight of -2.0 on h0 and +1.0 on h1, with the product scale shifted right by 4 using an arithmetic floor.
- R4: Code 0 selects the step function: 16 when net >= 0, else 0. Codes 5, 6 and 7 behave exactly like code 0.
- R5: Code 1 selects the sign function: +16 when net >= 0, else -16.
- R6: Code 2 selects the unit clip: 0 for net < 0, 16 for net > 16, otherwise net.
- R7: Code 3 selects the symmetric clip: -16 below -16, +16 above +16, otherwise net.
- R8: Code 4 selects the ramp: net when net >= 0, else 0.
- R9: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no result is pending or being computed.
- R10: After the accepting edge, `out_valid` stays low for one cycle and rises after the following edge, carrying the result.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `y` hold. An edge with both high consumes the result, and `in_ready` returns high after it.
- R12: Inputs and the activation code are sampled only at acceptance. Values presented while `in_ready` is low do not affect the pending result.
- R13: While reset is high, `out_valid` goes low and `in_ready` goes high after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Core can accept a pair |
| in_a | input | 3 | First unsigned network input |
| in_b | input | 3 | Second unsigned network input |
| act_sel | input | 3 | Activation code (0 step, 1 sign, 2 unit clip, 3 symmetric clip, 4 ramp, others step) |
| out_valid | output | 1 | Result available on y |
| out_ready | input | 1 | Consumer takes the result |
| y | output | 18 | Signed network output, 4 fractional bits |

## Verification
Every one of the 64 input pairs is run under each of the eight activation codes, so every clip boundary is crossed. That covers net values below, at and above zero, and beyond plus and minus one. The sweep also shows that the three unused codes match the step function. Because the unbounded ramp lets hidden outputs grow far past 1.0, the same sweep also exercises the widened sums and the floor shift in the output neuron. Each transaction applies a varying number of back-pressure cycles, with altered inputs and code offered while the core is busy. This separates correct holding and sampling behaviour from a core that re-samples its inputs or drops its result early.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

    localparam int IN_W     = 3;
    localparam int WT_W     = 7;
    localparam int FRAC     = 4;
    localparam int N_IN     = 2;
    localparam int N_HID    = 2;
    localparam int SUM_GROW = $clog2(N_IN + 2);
    localparam int H_W      = IN_W + 1 + WT_W + SUM_GROW;
    localparam int O_NET_W  = H_W + WT_W + SUM_GROW;
    localparam int Y_W      = O_NET_W - FRAC;

    typedef logic signed [WT_W-1:0] wt_t;
    typedef wt_t [N_IN:0] wvec_t;

    typedef enum logic [2:0] {
        ACT_STEP   = 3'd0,
        ACT_SIGN   = 3'd1,
        ACT_CLIP01 = 3'd2,
        ACT_CLIPPM = 3'd3,
        ACT_RAMP   = 3'd4
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } ctrl_state_e;

    localparam wt_t BIAS_ALL = 7'b0010000;

    // index 0 scales a constant unit input, index k scales input k-1
    localparam wvec_t W_HID0 = {7'b0010000, 7'b0010000, 7'b1101000};
    localparam wvec_t W_HID1 = {7'b0010000, 7'b0010000, 7'b1111000};
    localparam wvec_t W_OUT  = {7'b0010000, 7'b1100000, 7'b1111000};

    function automatic wvec_t hid_wts(int j);
        return (j == 0) ? W_HID0 : W_HID1;
    endfunction

    function automatic act_e decode_act(logic [2:0] code);
        case (code)
            3'd1:    return ACT_SIGN;
            3'd2:    return ACT_CLIP01;
            3'd3:    return ACT_CLIPPM;
            3'd4:    return ACT_RAMP;
            default: return ACT_STEP;
        endcase
    endfunction

endpackage

// File: rtl/mlp_act.sv
module mlp_act #(
    parameter int W = 13
) (
    input  mlp_pkg::act_e       sel,
    input  logic signed [W-1:0] net,
    output logic signed [W-1:0] y
);
    import mlp_pkg::*;

    localparam logic signed [W-1:0] ONE     = W'(1 << FRAC);
    localparam logic signed [W-1:0] NEG_ONE = -ONE;

    logic neg;
    assign neg = net[W-1];

    always_comb begin
        case (sel)
            ACT_SIGN:   y = neg ? NEG_ONE : ONE;
            ACT_CLIP01: y = neg ? '0 : ((net > ONE) ? ONE : net);
            ACT_CLIPPM: y = (net < NEG_ONE) ? NEG_ONE :
                            ((net > ONE) ? ONE : net);
            ACT_RAMP:   y = neg ? '0 : net;
            default:    y = neg ? '0 : ONE;
        endcase
    end

    always_comb begin
        if (sel == ACT_SIGN) begin
            // R5
            sign_levels_chk: assert (y == ONE || y == NEG_ONE);
        end
        if (sel == ACT_CLIP01) begin
            // R6
            clip01_range_chk: assert (y >= 0 && y <= ONE);
        end
        if (sel == ACT_CLIPPM) begin
            // R7
            clippm_range_chk: assert (y >= NEG_ONE && y <= ONE);
        end
        if (sel == ACT_RAMP) begin
            // R8
            ramp_nonneg_chk: assert (y >= 0);
        end
    end

endmodule

// File: rtl/mlp_neuron.sv
module mlp_neuron #(
    parameter int X_W    = 4,
    parameter int X_FRAC = 0,
    parameter int NET_W  = 13,
    parameter int O_W    = 13,
    parameter mlp_pkg::wt_t   BIAS = '0,
    parameter mlp_pkg::wvec_t WTS  = '0
) (
    input  mlp_pkg::act_e                        sel,
    input  logic [mlp_pkg::N_IN-1:0][X_W-1:0]    x,
    output logic signed [O_W-1:0]                y
);
    import mlp_pkg::*;

    localparam int N_T = N_IN + 1;
    localparam logic signed [NET_W-1:0] BIAS_S = NET_W'(BIAS) <<< X_FRAC;

    logic signed [NET_W-1:0] term [N_T];
    logic signed [NET_W-1:0] net_full;
    logic signed [O_W-1:0]   net;

    for (genvar i = 0; i < N_T; i++) begin : g_term
        logic signed [X_W-1:0] xi;
        if (i == 0) begin : g_unit
            assign xi = X_W'(1 << X_FRAC);
        end else begin : g_in
            assign xi = $signed(x[i-1]);
        end
        assign term[i] = NET_W'($signed(WTS[i])) * NET_W'(xi);
    end

    always_comb begin
        net_full = BIAS_S;
        for (int i = 0; i < N_T; i++) begin
            net_full = net_full + term[i];
        end
    end

    assign net = O_W'(net_full >>> X_FRAC);

    mlp_act #(.W(O_W)) u_act (
        .sel (sel),
        .net (net),
        .y   (y)
    );

endmodule

// File: rtl/mlp_ctrl.sv
module mlp_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic take_in,
    output logic load_out
);
    import mlp_pkg::*;

    ctrl_state_e state_q, state_d;

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_HOLD);
    assign take_in   = in_ready && in_valid;
    assign load_out  = (state_q == ST_CALC);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_CALC;
            ST_CALC:                state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R9
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || load_out) |-> !in_ready);

    // R10
    two_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        take_in |=> (!out_valid ##1 out_valid));

    // R11
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    // R11
    consume_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R13
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

endmodule

// File: rtl/mlp_core.sv
module mlp_core (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [2:0]                        in_a,
    input  logic [2:0]                        in_b,
    input  logic [2:0]                        act_sel,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic signed [mlp_pkg::Y_W-1:0]    y
);
    import mlp_pkg::*;

    logic take_in, load_out;
    act_e act_now, mode_q;

    logic [N_IN-1:0][IN_W:0]    x_in;
    logic [N_HID-1:0][H_W-1:0]  hid_d, hid_q;
    logic signed [Y_W-1:0]      y_d, y_q;

    mlp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .take_in   (take_in),
        .load_out  (load_out)
    );

    assign act_now = decode_act(act_sel);
    assign x_in[0] = {1'b0, in_a};
    assign x_in[1] = {1'b0, in_b};

    for (genvar j = 0; j < N_HID; j++) begin : g_hid
        mlp_neuron #(
            .X_W    (IN_W + 1),
            .X_FRAC (0),
            .NET_W  (H_W),
            .O_W    (H_W),
            .BIAS   (BIAS_ALL),
            .WTS    (hid_wts(j))
        ) u_hid (
            .sel (act_now),
            .x   (x_in),
            .y   (hid_d[j])
        );
    end

    mlp_neuron #(
        .X_W    (H_W),
        .X_FRAC (FRAC),
        .NET_W  (O_NET_W),
        .O_W    (Y_W),
        .BIAS   (BIAS_ALL),
        .WTS    (W_OUT)
    ) u_out (
        .sel (mode_q),
        .x   (hid_q),
        .y   (y_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hid_q  <= '0;
            mode_q <= ACT_STEP;
            y_q    <= '0;
        end else begin
            if (take_in) begin
                hid_q  <= hid_d;
                mode_q <= act_now;
            end
            if (load_out) begin
                y_q <= y_d;
            end
        end
    end

    assign y = y_q;

    // R11
    y_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(y));

    // R12
    busy_sample_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> ($stable(hid_q) && $stable(mode_q)));

endmodule

// File: tb/mlp_core_bench.sv
module mlp_core_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [2:0]        in_a = '0;
    logic [2:0]        in_b = '0;
    logic [2:0]        act_sel = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic signed [17:0] y;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mlp_core u_mlp_core (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .act_sel   (act_sel),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .y         (y)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4 R5 R6 R7 R8: activation reference, raw units of 1/16
    function automatic int act_ref(input int n, input int code);
        case (code)
            1:       return (n >= 0) ? 16 : -16;
            2:       return (n < 0) ? 0 : ((n > 16) ? 16 : n);
            3:       return (n < -16) ? -16 : ((n > 16) ? 16 : n);
            4:       return (n < 0) ? 0 : n;
            default: return (n >= 0) ? 16 : 0;
        endcase
    endfunction

    // R1 R2 R3: network reference
    function automatic int net_ref(input int a, input int b, input int code);
        int h0, h1, onet;
        h0 = act_ref(16 - 24 + 16 * a + 16 * b, code);
        h1 = act_ref(16 - 8 + 16 * a + 16 * b, code);
        onet = (256 - 128 - 32 * h0 + 16 * h1) >>> 4;
        return act_ref(onet, code);
    endfunction

    task automatic run_txn(input int a, input int b, input int code, input int stall);
        int exp;
        int held;
        exp = net_ref(a, b, code);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready when idle", int'(in_ready), 1);
        in_a = 3'(a); in_b = 3'(b); act_sel = 3'(code); in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 no result one cycle after accept", int'(out_valid), 0);
        // R12: offer different values while busy
        in_a = 3'(~a); in_b = 3'(~b); act_sel = 3'(code ^ 1);
        in_valid = (stall > 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R10 result after second edge", int'(out_valid), 1);
        if (code >= 5)
            chk(int'(y) == exp, "R4 unused code acts as step", int'(y), exp);
        else if (code == 1)
            chk(int'(y) == exp, "R5 sign output", int'(y), exp);
        else if (code == 2)
            chk(int'(y) == exp, "R6 unit clip output", int'(y), exp);
        else if (code == 3)
            chk(int'(y) == exp, "R7 symmetric clip output", int'(y), exp);
        else if (code == 4)
            chk(int'(y) == exp, "R8 ramp output R2 R3", int'(y), exp);
        else
            chk(int'(y) == exp, "R4 step output R2 R3", int'(y), exp);
        held = int'(y);
        for (int s = 0; s < stall; s++) begin
            chk(in_ready == 1'b0, "R9 not ready while holding", int'(in_ready), 0);
            @(negedge clk);
            chk(out_valid == 1'b1 && int'(y) == held, "R11 result held", int'(y), held);
            chk(int'(y) == exp, "R12 busy inputs ignored", int'(y), exp);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R11 consumed then ready",
            int'({out_valid, in_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R13 reset state",
            int'({out_valid, in_ready}), 1);
        rst = 1'b0;
        // R1: full sweep, every code, all 64 pairs
        for (int code = 0; code < 8; code++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    run_txn(a, b, code, (a + b + code) % 3);
                end
            end
        end
        // R13: reset while a result is held
        @(negedge clk);
        in_a = 3'd3; in_b = 3'd2; act_sel = 3'd4; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R13 reset clears pending",
            int'({out_valid, in_ready}), 1);
        rst = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule